// File: doc/BRIEF.md
# Toggle-Clocked Byte Handshake Engine

This block sits between a host processor and a peripheral controller and moves whole packets one byte at a time through a shared 8-bit data latch. The host owns two active-low lines: a transfer-in-progress strobe and an acknowledge strobe. The controller answers on one active-low request line. No serial clock is used. Any change in the pair of host strobes, compared with the previous clock's sample, moves exactly one byte. A direction input selects whether the host is writing bytes into the outbound buffer or reading bytes from the inbound buffer.

Each handshake event also starts a programmable delay. When the delay runs out, the block gives a one-cycle shift-register interrupt. Another event during the delay restarts it. When the host ends a transfer, the block reports a completed outbound packet with its length, and the controller side reads the bytes back by index. Inbound packets arrive as a byte stream with valid/ready flow control. The source may present a byte at any time, and a byte counts as accepted only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is held low while any byte of the previous packet is still unread, so the source must keep `in_data`/`in_last` stable until acceptance. A hold flag tells background logic to stay off the link from the first outbound byte until the final inbound byte has been delivered.

Top module: `hs_engine`

## Requirements
- R1: After reset `treq_n` is 1, `sr_irq`, `hold` and `pkt_rcvd` are 0, `in_ready` is 1, and any pending delayed interrupt is cancelled.
- R2: While `tip_n` is 0 and `dir_out` is 1, each clock in which {`tack_n`,`tip_n`} differs from the previous clock's sample stores `sr_wdata` at the next outbound index, starting from index 0.
- R3: When the outbound buffer already holds OB_DEPTH bytes, further outbound bytes are dropped, and the packet length saturates at OB_DEPTH.
- R4: In the clock where `tip_n` is first sampled 1 after being 0, the outbound index returns to 0. `pkt_rcvd` pulses for one cycle with `pkt_len` equal to the byte count only if that count is nonzero.
- R5: While `tip_n` is 0 and `dir_out` is 0 with unread inbound bytes, each change of the strobe pair loads the next inbound byte onto `sr_q`. Loading the last byte drives `treq_n` to 1.
- R6: While `tip_n` is 1 (outside the sync case) and unread inbound bytes remain, `treq_n` is driven to 0. This also holds in the clock an inbound packet is committed while `tip_n` is 1.
- R7: When `tip_n` was 1 on the previous sample and is still 1, a change of `tack_n` copies the new `tack_n` level onto `treq_n`.
- R8: Every byte move, sync toggle and transfer end gives a single-cycle `sr_irq` exactly DLY_CYC clocks after the event's edge. A new event restarts the delay.
- R9: `hold` rises with the first outbound byte of a packet and falls together with the release of `treq_n` when the final inbound byte is delivered.
- R10: `in_ready` is 1 exactly when every inbound byte has been read. An inbound byte is accepted when `in_valid` and `in_ready` are both 1. `in_last`, or filling the IB_DEPTH-th byte, commits the packet and resets the read index to 0.
- R11: A clock with no change in the strobe pair moves no byte and leaves `sr_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tip_n | input | 1 | Host transfer-in-progress, active low |
| tack_n | input | 1 | Host acknowledge strobe, active low |
| dir_out | input | 1 | 1: host sends to controller; 0: host receives |
| sr_wdata | input | 8 | Byte the host has written into the data latch |
| sr_q | output | 8 | Inbound byte presented to the host |
| treq_n | output | 1 | Controller request line, active low |
| sr_irq | output | 1 | Delayed shift-register interrupt pulse |
| hold | output | 1 | Background-polling hold flag |
| in_valid | input | 1 | Inbound stream byte valid |
| in_ready | output | 1 | Inbound stream ready |
| in_data | input | 8 | Inbound stream byte |
| in_last | input | 1 | Marks final byte of the inbound packet |
| pkt_rcvd | output | 1 | One-cycle pulse: outbound packet complete |
| pkt_len | output | $clog2(OB_DEPTH+1) | Byte count of the last completed outbound packet |
| rd_idx | input | $clog2(OB_DEPTH) | Outbound buffer read index |
| rd_byte | output | 8 | Outbound buffer byte at `rd_idx` |

## Verification
The host-write path is driven with a strobe sequence that mixes transfer-start edges and acknowledge toggles in both directions, with one repeated sample in the middle. Reading the buffer back then shows that each edge stores exactly one byte and that a held sample stores none. A zero-byte transfer separates the end-of-transfer interrupt from the packet strobe, and a six-byte burst into a four-entry buffer shows the saturation. On the read side, inbound packets are committed with the host both idle and mid-transfer, which separates the request asserted at commit from the request asserted at the rising transfer edge. Acknowledge toggles with the transfer idle exercise the sync path, and a reset taken inside a pending delay shows that the interrupt is cancelled.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef struct packed {
    logic tack_n;
    logic tip_n;
  } hs_pair_t;

  localparam hs_pair_t HS_IDLE = '{tack_n: 1'b1, tip_n: 1'b1};
endpackage

// File: rtl/hs_sampler.sv
module hs_sampler
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tip_n,
  input  logic tack_n,
  output logic prev_tip_n,
  output logic prev_tack_n,
  output logic pair_chg
);
  hs_pair_t cur, prev;

  assign cur = '{tack_n: tack_n, tip_n: tip_n};

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= HS_IDLE;
    else        prev <= cur;
  end

  assign prev_tip_n  = prev.tip_n;
  assign prev_tack_n = prev.tack_n;
  assign pair_chg    = (cur != prev);
endmodule

// File: rtl/hs_irq_delay.sv
module hs_irq_delay #(
  parameter int DLY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic irq
);
  localparam int CW = $clog2(DLY_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= !trig && (cnt == CW'(1));
      if (trig)            cnt <= CW'(DLY_CYC);
      else if (cnt != '0)  cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/hs_ib_buffer.sv
module hs_ib_buffer #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  input  logic       pop,
  output logic [7:0] pop_data,
  output logic       has_data,
  output logic       is_last,
  output logic       commit
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] fill;
  logic [LW-1:0] len, rd;

  assign has_data = (rd < len);
  assign is_last  = (rd + LW'(1) == len);
  assign pop_data = mem[rd[AW-1:0]];
  assign commit   = wr && (wr_last || fill == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (wr) mem[fill] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
      len  <= '0;
      rd   <= '0;
    end else if (commit) begin
      fill <= '0;
      len  <= LW'(fill) + LW'(1);
      rd   <= '0;
    end else begin
      if (wr)  fill <= fill + AW'(1);
      if (pop) rd   <= rd + LW'(1);
    end
  end
endmodule

// File: rtl/hs_engine.sv
module hs_engine #(
  parameter int OB_DEPTH = 16,
  parameter int IB_DEPTH = 16,
  parameter int DLY_CYC  = 16,
  localparam int OLW = $clog2(OB_DEPTH + 1),
  localparam int OAW = $clog2(OB_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tip_n,
  input  logic           tack_n,
  input  logic           dir_out,
  input  logic [7:0]     sr_wdata,
  output logic [7:0]     sr_q,
  output logic           treq_n,
  output logic           sr_irq,
  output logic           hold,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  input  logic           in_last,
  output logic           pkt_rcvd,
  output logic [OLW-1:0] pkt_len,
  input  logic [OAW-1:0] rd_idx,
  output logic [7:0]     rd_byte
);
  logic prev_tip_n, prev_tack_n, pair_chg;
  logic ib_has, ib_last, ib_commit;
  logic [7:0] ib_byte;
  logic ev_out, ev_in, ev_sync, ev_end, sched;
  logic [OLW-1:0] ob_idx;
  logic [7:0] ob_mem [OB_DEPTH];

  hs_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .tack_n(tack_n),
    .prev_tip_n(prev_tip_n), .prev_tack_n(prev_tack_n), .pair_chg(pair_chg)
  );

  assign in_ready = !ib_has;

  hs_ib_buffer #(.DEPTH(IB_DEPTH)) u_ib (
    .clk(clk), .rst_n(rst_n),
    .wr(in_valid && in_ready), .wr_data(in_data), .wr_last(in_last),
    .pop(ev_in), .pop_data(ib_byte), .has_data(ib_has),
    .is_last(ib_last), .commit(ib_commit)
  );

  // event decode
  assign ev_out  = !tip_n && dir_out  && pair_chg && (ob_idx < OLW'(OB_DEPTH));
  assign ev_in   = !tip_n && !dir_out && pair_chg && ib_has;
  assign ev_sync = tip_n && prev_tip_n && (tack_n != prev_tack_n);
  assign ev_end  = tip_n && !prev_tip_n;
  assign sched   = ev_out || ev_in || ev_sync || ev_end;

  hs_irq_delay #(.DLY_CYC(DLY_CYC)) u_dly (
    .clk(clk), .rst_n(rst_n), .trig(sched), .irq(sr_irq)
  );

  always_ff @(posedge clk) begin
    if (ev_out) ob_mem[ob_idx[OAW-1:0]] <= sr_wdata;
  end
  assign rd_byte = ob_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_idx   <= '0;
      pkt_len  <= '0;
      pkt_rcvd <= 1'b0;
      hold     <= 1'b0;
      treq_n   <= 1'b1;
      sr_q     <= '0;
    end else begin
      pkt_rcvd <= ev_end && (ob_idx != '0);
      if (ev_end) begin
        ob_idx  <= '0;
        pkt_len <= ob_idx;
      end else if (ev_out) begin
        ob_idx <= ob_idx + OLW'(1);
      end

      if (ev_out && ob_idx == '0)  hold <= 1'b1;
      else if (ev_in && ib_last)   hold <= 1'b0;

      if (ev_in) sr_q <= ib_byte;

      if (ib_commit && tip_n)      treq_n <= 1'b0;
      else if (ev_in && ib_last)   treq_n <= 1'b1;
      else if (ev_sync)            treq_n <= tack_n;
      else if (tip_n && ib_has)    treq_n <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_engine_chk.sv
module hs_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic tip_n,
  input logic tack_n,
  input logic dir_out,
  input logic in_valid,
  input logic in_ready,
  input logic treq_n,
  input logic sr_irq,
  input logic hold,
  input logic pkt_rcvd
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (treq_n && !sr_irq && !hold && !pkt_rcvd && in_ready));

  a_r4_pkt_single: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rcvd |=> !pkt_rcvd);

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    sr_irq |=> !sr_irq);

  a_r9_hold_from_host_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(hold)) |-> $past(!tip_n && dir_out));

  a_r9_hold_drop_releases_req: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(hold)) |-> treq_n);

  a_r7_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tip_n && $past(tip_n) && (tack_n != $past(tack_n)) && !(in_valid && in_ready))
      |=> (treq_n == $past(tack_n)));
endmodule

bind hs_engine hs_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .tack_n(tack_n), .dir_out(dir_out),
  .in_valid(in_valid), .in_ready(in_ready), .treq_n(treq_n), .sr_irq(sr_irq),
  .hold(hold), .pkt_rcvd(pkt_rcvd)
);

// File: tb/sim_hs_engine.sv
module sim_hs_engine;
  localparam int PERIOD = 10;
  localparam int OBD = 4;
  localparam int IBD = 4;
  localparam int DLY = 8;
  localparam int OLW = $clog2(OBD + 1);
  localparam int OAW = $clog2(OBD);

  logic clk = 1'b0;
  logic rst_n, tip_n, tack_n, dir_out, in_valid, in_last;
  logic [7:0] sr_wdata, in_data, sr_q, rd_byte;
  logic treq_n, sr_irq, hold, in_ready, pkt_rcvd;
  logic [OLW-1:0] pkt_len;
  logic [OAW-1:0] rd_idx;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  hs_engine #(.OB_DEPTH(OBD), .IB_DEPTH(IBD), .DLY_CYC(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .tack_n(tack_n), .dir_out(dir_out),
    .sr_wdata(sr_wdata), .sr_q(sr_q), .treq_n(treq_n), .sr_irq(sr_irq), .hold(hold),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .pkt_rcvd(pkt_rcvd), .pkt_len(pkt_len), .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  // row: {tip_n, tack_n, data[7:0], exp_pkt_rcvd, exp_hold}
  localparam logic [11:0] VEC [5] = '{
    {1'b0, 1'b1, 8'hA1, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'hB2, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'hC3, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'hD4, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h00, 1'b1, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, int idx, logic [7:0] exp);
    rd_idx = OAW'(idx);
    #1;
    chk(req, {24'h0, rd_byte}, {24'h0, exp});
  endtask

  // wait out a delay window after an event tick; irq must appear exactly at DLY
  task automatic irq_window(string req);
    int early = 0;
    for (int i = 0; i < DLY - 1; i++) begin
      tick();
      if (sr_irq) early++;
    end
    chk(req, early, 0);
    tick();
    chk(req, {31'h0, sr_irq}, 1);
    tick();
    chk(req, {31'h0, sr_irq}, 0);
  endtask

  task automatic push(logic [7:0] d, logic last);
    in_valid = 1'b1; in_data = d; in_last = last;
    tick();
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tip_n = 1'b1; tack_n = 1'b1; dir_out = 1'b1;
    sr_wdata = '0; in_valid = 1'b0; in_data = '0; in_last = 1'b0; rd_idx = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 treq_n", {31'h0, treq_n}, 1);
    chk("R1 sr_irq", {31'h0, sr_irq}, 0);
    chk("R1 hold", {31'h0, hold}, 0);
    chk("R1 pkt_rcvd", {31'h0, pkt_rcvd}, 0);
    chk("R1 in_ready", {31'h0, in_ready}, 1);

    // table walk: host writes a packet (R2, R4, R9, R11, R8 retrigger)
    foreach (VEC[i]) begin
      tip_n = VEC[i][11]; tack_n = VEC[i][10]; sr_wdata = VEC[i][9:2];
      tick();
      chk("R4 pkt_rcvd row", {31'h0, pkt_rcvd}, {31'h0, VEC[i][1]});
      chk("R9 hold row", {31'h0, hold}, {31'h0, VEC[i][0]});
      chk("R8 no early irq row", {31'h0, sr_irq}, 0);
    end
    chk("R4 pkt_len", {29'h0, pkt_len}, 3);
    rd_chk("R2 byte0", 0, 8'hA1);
    rd_chk("R2 byte1", 1, 8'hB2);
    rd_chk("R11 held sample skipped", 2, 8'hD4);
    irq_window("R8 delay after end");
    chk("R4 pulse gone", {31'h0, pkt_rcvd}, 0);

    // zero-byte transfer: no packet strobe, interrupt still delayed (R4, R8)
    dir_out = 1'b0;
    tip_n = 1'b0; tick();
    tip_n = 1'b1; tick();
    chk("R4 empty no pulse", {31'h0, pkt_rcvd}, 0);
    irq_window("R8 end of empty transfer");

    // overflow (R3)
    dir_out = 1'b1;
    tip_n = 1'b0; sr_wdata = 8'h10; tick();
    for (int k = 1; k < 6; k++) begin
      tack_n = ~tack_n; sr_wdata = 8'h10 + 8'(k); tick();
    end
    tip_n = 1'b1; tick();
    chk("R3 pulse", {31'h0, pkt_rcvd}, 1);
    chk("R3 len saturates", {29'h0, pkt_len}, OBD);
    rd_chk("R3 last kept", 3, 8'h13);
    rd_chk("R2 first of new packet at 0", 0, 8'h10);
    repeat (DLY + 2) tick();

    // inbound commit while host idle (R10, R6)
    chk("R10 ready idle", {31'h0, in_ready}, 1);
    push(8'h5A, 1'b0);
    chk("R6 no req before commit", {31'h0, treq_n}, 1);
    push(8'h6B, 1'b0);
    push(8'h7C, 1'b1);
    chk("R6 req at commit", {31'h0, treq_n}, 0);
    chk("R10 ready low with unread", {31'h0, in_ready}, 0);

    // host reads (R5, R11, R9)
    dir_out = 1'b0;
    tip_n = 1'b0; tick();
    chk("R5 byte0", {24'h0, sr_q}, 8'h5A);
    chk("R5 req held", {31'h0, treq_n}, 0);
    tick();
    chk("R11 no move on stable", {24'h0, sr_q}, 8'h5A);
    tack_n = ~tack_n; tick();
    chk("R5 byte1", {24'h0, sr_q}, 8'h6B);
    tack_n = ~tack_n; tick();
    chk("R5 byte2", {24'h0, sr_q}, 8'h7C);
    chk("R5 req released", {31'h0, treq_n}, 1);
    chk("R9 hold dropped", {31'h0, hold}, 0);
    chk("R10 ready again", {31'h0, in_ready}, 1);
    tip_n = 1'b1; tick();
    chk("R6 no req when drained", {31'h0, treq_n}, 1);

    // sync case (R7)
    tack_n = 1'b1; tick();
    tack_n = 1'b0; tick();
    chk("R7 follows low", {31'h0, treq_n}, 0);
    tick();
    chk("R7 stays", {31'h0, treq_n}, 0);
    tack_n = 1'b1; tick();
    chk("R7 follows high", {31'h0, treq_n}, 1);

    // commit mid-transfer, request on transfer end (R6)
    tip_n = 1'b0; tick();
    push(8'h99, 1'b1);
    chk("R6 no req while tip low", {31'h0, treq_n}, 1);
    tick();
    chk("R11 no load without edge", {24'h0, sr_q}, 8'h7C);
    tip_n = 1'b1; tick();
    chk("R6 req on tip rise", {31'h0, treq_n}, 0);
    tip_n = 1'b0; tick();
    chk("R5 single byte", {24'h0, sr_q}, 8'h99);
    chk("R5 single release", {31'h0, treq_n}, 1);

    // reset inside a pending delay cancels it (R1)
    rst_n = 1'b0; tip_n = 1'b1; tick();
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < DLY + 3; i++) begin
        tick();
        if (sr_irq) seen++;
      end
      chk("R1 pending irq cancelled", seen, 0);
    end
    chk("R1 req after reset", {31'h0, treq_n}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule